// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit entries, each a small state machine that stores a predicted direction and whether the last prediction for that entry was right or wrong. The table is addressed by a slice of the fetch PC together with a short global history of recent branch outcomes. The history picks one of several banks, so the same branch can hold a different prediction for each recent outcome pattern.

The fetch stage presents a PC on the lookup port and gets a taken/not-taken guess back in the same cycle. It also gets the history value that chose the bank, and it carries that value down the pipeline with the branch. When the branch resolves in execute, the update port receives the branch PC, the carried history, the actual outcome and the prediction that was made. The entry is then moved on, and the outcome is shifted into the global history.

Top module: `branch_dir_pred`

## Requirements
- R1: After reset every entry holds predict-not-taken in the right state, so `lk_taken_o` is 0 for every PC, and `lk_hist_o` is 0.
- R2: The entry address is {history, PC[IDX_W+1:2]}. PC bits 1:0 and the bits above IDX_W+1 do not affect which entry is used.
- R3: `lk_taken_o` is combinational from `lk_pc_i` and the current history, and is valid in the same cycle. `lk_taken_o` = 1 means taken.
- R4: An update is a miss when `up_pred_i` differs from `up_taken_i`. In a right state, a hit leaves the entry unchanged. In a right state, a miss moves the entry to the wrong state with the same direction, so the prediction does not change.
- R5: In a wrong state, a second consecutive miss flips the direction and enters the right state. In a wrong state, a hit returns to the right state with the same direction. The direction therefore flips only after two misses in a row.
- R6: Each valid update shifts `up_taken_i` into bit 0 of the history, and the older bits move up by one position.
- R7: An update writes the bank selected by `up_hist_i`, not the bank selected by the current history.
- R8: When a lookup and an update hit the same entry in the same cycle, the lookup returns the value held before that update. The new value is visible from the next cycle.
- R9: While `up_valid_i` is low, neither the table nor the history changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | Fetch PC to predict |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| lk_hist_o | output | HIST_W | History that selected the bank; carry it to the update |
| up_valid_i | input | 1 | Resolved branch update strobe |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_hist_i | input | HIST_W | History captured when this branch was looked up |
| up_taken_i | input | 1 | Actual outcome, 1 = taken |
| up_pred_i | input | 1 | Prediction that was given for this branch |

## Verification
The bench drives one entry through the full hysteresis cycle. A design that flips on the first miss, or fails to clear the wrong flag on a hit, would give the wrong direction after the single-miss steps. Aliased PCs that differ only in the dropped low bits or in the high bits must land on the same entry. An update written with a stale history must land in the bank it names, not in the live one; an implementation that indexes with the current history would corrupt a different entry. A same-cycle lookup and update to one entry must read the old value before the edge and the new value after it. An update input moving while the strobe is low must change nothing.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef struct packed {
    logic dir;    // 1 = predict taken
    logic wrong;  // last prediction of this entry missed
  } bdp_ent_t;

  localparam bdp_ent_t ENT_RST = '{dir: 1'b0, wrong: 1'b0};
endpackage

// File: rtl/bdp_fsm.sv
module bdp_fsm
  import bdp_pkg::*;
(
  input  bdp_ent_t ent_i,
  input  logic     miss_i,
  output bdp_ent_t ent_o
);
  always_comb begin
    ent_o = ent_i;
    if (!ent_i.wrong) begin
      if (miss_i) ent_o.wrong = 1'b1;
    end else begin
      ent_o.wrong = 1'b0;
      if (miss_i) ent_o.dir = ~ent_i.dir;
    end
  end
endmodule

// File: rtl/bdp_hist.sv
module bdp_hist #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = bit_i;
    end else begin : g_shift
      assign hist_d = {hist_q[HIST_W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output bdp_ent_t      rd_ent_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_miss_i,
  output bdp_ent_t      wr_old_o,
  output bdp_ent_t      wr_new_o
);
  localparam int unsigned ENTRIES = 1 << AW;

  bdp_ent_t mem_q [ENTRIES];

  assign rd_ent_o = mem_q[rd_idx_i];
  assign wr_old_o = mem_q[wr_idx_i];

  bdp_fsm u_fsm (
    .ent_i  (wr_old_o),
    .miss_i (wr_miss_i),
    .ent_o  (wr_new_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= ENT_RST;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_new_o;
    end
  end
endmodule

// File: rtl/branch_dir_pred.sv
module branch_dir_pred
  import bdp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic              lk_taken_o,
  output logic [HIST_W-1:0] lk_hist_o,
  input  logic              up_valid_i,
  input  logic [PC_W-1:0]   up_pc_i,
  input  logic [HIST_W-1:0] up_hist_i,
  input  logic              up_taken_i,
  input  logic              up_pred_i
);
  localparam int unsigned AW = HIST_W + IDX_W;

  logic [HIST_W-1:0] hist;
  logic [AW-1:0]     rd_idx, wr_idx;
  bdp_ent_t          rd_ent, wr_old, wr_new;

  bdp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (up_valid_i),
    .bit_i   (up_taken_i),
    .hist_o  (hist)
  );

  assign rd_idx = {hist,      lk_pc_i[IDX_W+1:2]};
  assign wr_idx = {up_hist_i, up_pc_i[IDX_W+1:2]};

  bdp_table #(.AW(AW)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_ent_o  (rd_ent),
    .wr_en_i   (up_valid_i),
    .wr_idx_i  (wr_idx),
    .wr_miss_i (up_pred_i ^ up_taken_i),
    .wr_old_o  (wr_old),
    .wr_new_o  (wr_new)
  );

  assign lk_taken_o = rd_ent.dir;
  assign lk_hist_o  = hist;

  logic unused_bits;
  assign unused_bits = ^{lk_pc_i[PC_W-1:IDX_W+2], lk_pc_i[1:0],
                         up_pc_i[PC_W-1:IDX_W+2], up_pc_i[1:0], rd_ent.wrong};
endmodule

// File: rtl/branch_dir_pred_chk.sv
module branch_dir_pred_chk
  import bdp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   lk_pc_i,
  input logic              lk_taken_o,
  input logic [HIST_W-1:0] lk_hist_o,
  input logic              up_valid_i,
  input logic              up_taken_i,
  input logic              up_pred_i,
  input bdp_ent_t          wr_old,
  input bdp_ent_t          wr_new
);
  p_hist_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> lk_hist_o == HIST_W'({$past(lk_hist_o), $past(up_taken_i)}));

  p_hist_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(lk_hist_o));

  p_lookup_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!up_valid_i) && $stable(lk_pc_i)) |-> $stable(lk_taken_o));

  p_right_hit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && (up_pred_i == up_taken_i) && !wr_old.wrong) |-> wr_new == wr_old);

  p_right_miss_keep_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !wr_old.wrong) |-> wr_new.dir == wr_old.dir);

  p_flip_needs_two_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && (wr_new.dir != wr_old.dir)) |-> (wr_old.wrong && (up_pred_i != up_taken_i)));
endmodule

bind branch_dir_pred branch_dir_pred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_pc_i    (lk_pc_i),
  .lk_taken_o (lk_taken_o),
  .lk_hist_o  (lk_hist_o),
  .up_valid_i (up_valid_i),
  .up_taken_i (up_taken_i),
  .up_pred_i  (up_pred_i),
  .wr_old     (wr_old),
  .wr_new     (wr_new)
);

// File: tb/branch_dir_pred_bench.sv
module branch_dir_pred_bench;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 2;
  localparam int N_ENT  = 1 << (IDX_W + HIST_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PC_W-1:0]   lk_pc = '0;
  logic              lk_taken;
  logic [HIST_W-1:0] lk_hist;
  logic              up_valid = 1'b0;
  logic [PC_W-1:0]   up_pc = '0;
  logic [HIST_W-1:0] up_hist = '0;
  logic              up_taken = 1'b0;
  logic              up_pred = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference: bit1 = direction, bit0 = wrong flag
  logic [1:0]        ref_tab [N_ENT];
  logic [HIST_W-1:0] ref_hist;

  always #4 clk = ~clk;

  branch_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_branch_dir_pred (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .lk_pc_i    (lk_pc),
    .lk_taken_o (lk_taken),
    .lk_hist_o  (lk_hist),
    .up_valid_i (up_valid),
    .up_pc_i    (up_pc),
    .up_hist_i  (up_hist),
    .up_taken_i (up_taken),
    .up_pred_i  (up_pred)
  );

  function automatic int ent_of(logic [HIST_W-1:0] h, logic [PC_W-1:0] pc);
    return int'({h, pc[IDX_W+1:2]});
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic ref_update(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] bank,
                            input logic taken, input logic pred);
    int e;
    logic [1:0] s;
    e = ent_of(bank, pc);
    s = ref_tab[e];
    if (s[0] == 1'b0) s[0] = (taken != pred);
    else begin
      if (taken != pred) s[1] = ~s[1];
      s[0] = 1'b0;
    end
    ref_tab[e] = s;
    ref_hist = HIST_W'({ref_hist, taken});
  endtask

  // one update cycle, inputs held from one falling edge to the next
  task automatic do_update(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] bank,
                           input logic taken, input logic pred);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_hist = bank; up_taken = taken; up_pred = pred;
    @(negedge clk);
    up_valid = 1'b0;
    ref_update(pc, bank, taken, pred);
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    lk_pc = pc;
    #1;
    chk({7'd0, lk_taken}, {7'd0, ref_tab[ent_of(ref_hist, pc)][1]}, {req, " prediction"});
    chk(8'(lk_hist), 8'(ref_hist), {req, " history"});
  endtask

  // update into the bank the history will hold afterwards, then look it up
  task automatic upd_see(input logic [PC_W-1:0] pc, input logic taken, input logic pred,
                         input logic exp_dir, input string req);
    do_update(pc, HIST_W'({ref_hist, taken}), taken, pred);
    look(pc, req);
    chk({7'd0, lk_taken}, {7'd0, exp_dir}, {req, " expected direction"});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(8'(lk_hist), 8'd0, "R1 history after reset");
    look(32'h0000_0000, "R1");
    look(32'h0000_10fc, "R1");
    look(32'hffff_fffc, "R1");
  endtask

  task automatic t_hysteresis;
    // warm history to all ones so every update below hits bank 11
    do_update(32'h0000_2000, 2'b00, 1'b1, 1'b1);
    do_update(32'h0000_2000, 2'b01, 1'b1, 1'b1);
    upd_see(32'h0000_1040, 1'b1, 1'b1, 1'b0, "R4 hit in right state holds");
    upd_see(32'h0000_1040, 1'b1, 1'b0, 1'b0, "R4 first miss keeps direction");
    upd_see(32'h0000_1040, 1'b1, 1'b0, 1'b1, "R5 second miss flips");
    upd_see(32'h0000_1040, 1'b1, 1'b0, 1'b1, "R4 miss from taken-right keeps");
    upd_see(32'h0000_1040, 1'b1, 1'b1, 1'b1, "R5 hit in wrong state recovers");
    upd_see(32'h0000_1040, 1'b1, 1'b0, 1'b1, "R5 single miss after recovery");
    upd_see(32'h0000_1040, 1'b1, 1'b0, 1'b0, "R5 second miss flips back");
    chk(8'(lk_hist), 8'd3, "R6 history after taken run");
  endtask

  task automatic t_stale_bank;
    // write bank 00 while the live history is 11
    do_update(32'h0000_1040, 2'b00, 1'b1, 1'b0);
    do_update(32'h0000_1040, 2'b00, 1'b1, 1'b0);
    look(32'h0000_1040, "R7 live bank untouched");
    chk({7'd0, lk_taken}, 8'd0, "R7 live bank still not taken");
    do_update(32'h0000_3000, 2'b10, 1'b0, 1'b0);
    chk(8'(lk_hist), 8'd2, "R6 shift in not-taken");
    do_update(32'h0000_3000, 2'b00, 1'b0, 1'b0);
    look(32'h0000_1040, "R7 named bank written");
    chk({7'd0, lk_taken}, 8'd1, "R7 bank 00 now taken");
  endtask

  task automatic t_alias;
    look(32'h0000_1043, "R2 low bits ignored");
    chk({7'd0, lk_taken}, 8'd1, "R2 low bits alias");
    look(32'h0000_1140, "R2 high bits ignored");
    chk({7'd0, lk_taken}, 8'd1, "R2 high bits alias");
    look(32'hf000_1040, "R2 top bits ignored");
    look(32'h0000_1044, "R2 neighbour entry");
    chk({7'd0, lk_taken}, 8'd0, "R2 neighbour independent");
    // same phase, two PCs: output follows immediately
    look(32'h0000_1040, "R3 combinational lookup");
    look(32'h0000_1044, "R3 combinational lookup");
  endtask

  task automatic t_same_cycle;
    // history 00, taken=0 keeps it 00; pred=1 makes each update a miss
    do_update(32'h0000_0080, 2'b00, 1'b0, 1'b1);
    look(32'h0000_0080, "R8 setup");
    @(negedge clk);
    lk_pc = 32'h0000_0080;
    up_valid = 1'b1; up_pc = 32'h0000_0080; up_hist = 2'b00; up_taken = 1'b0; up_pred = 1'b1;
    #1;
    chk({7'd0, lk_taken}, 8'd0, "R8 old value during update cycle");
    @(negedge clk);
    up_valid = 1'b0;
    ref_update(32'h0000_0080, 2'b00, 1'b0, 1'b1);
    #1;
    chk({7'd0, lk_taken}, 8'd1, "R8 new value next cycle");
  endtask

  task automatic t_idle;
    @(negedge clk);
    up_valid = 1'b0; up_pc = 32'h0000_0080; up_hist = 2'b00; up_taken = 1'b1; up_pred = 1'b0;
    repeat (3) @(negedge clk);
    look(32'h0000_0080, "R9 table unchanged without strobe");
    chk({7'd0, lk_taken}, 8'd1, "R9 entry kept");
    chk(8'(lk_hist), 8'd0, "R9 history kept");
  endtask

  initial begin
    for (int i = 0; i < N_ENT; i++) ref_tab[i] = 2'b00;
    ref_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hysteresis();
    t_stale_bank();
    t_alias();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule